// File: doc/BRIEF.md
# Prioritized Interrupt Request Controller

This block gathers interrupt requests from thirteen maskable sources (one external request pin plus twelve on-chip timer, periodic-tick and serial sources), from a second external pin that has its own mask, and from a reset-class request. It applies a global mask and per-source enables, picks a single winner by a fixed order, and lets software lift one maskable source above all the others through a promotion code. The winner's vector address goes to the CPU together with a request line.

The CPU side is a valid/ready pair. `irq_o` is the valid and `ack_i` is the ready. Requests are sampled only on the CPU's instruction-boundary strobe. Once `irq_o` is raised it stays high, and `vec_o` does not change, until the CPU acknowledges. Back-pressure is unlimited: a held request waits for as many cycles as the CPU takes, and no new choice is made during that time. When the acknowledge arrives, the global mask is set. When the winner was the separately masked pin or the reset-class source, that pin's mask is set as well. The mask bits come from plain register-interface inputs. The global mask can be written to either value. The pin mask can only be cleared.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the global mask `imask_o` is 1, the pin mask `xmask_o` is 1 and `irq_o` is 0.
- R2: A write with `imask_we_i` high loads `imask_d_i` into the global mask. While the global mask is 1, no maskable source is taken at a boundary strobe.
- R3: A pulse on `xmask_clr_i` clears the pin mask, and no register input can set it. While the pin mask is 1, `xirq_i` is ignored.
- R4: A maskable source whose bit in `src_en_i` is 0 is never taken, even when it is requesting.
- R5: Source index k (0 external request, 1 periodic tick, 2 to 4 captures 1 to 3, 5 to 9 compares 1 to 5, 10 timer overflow, 11 pulse accumulator, 12 serial) has vector 0xFFF2 - 2k. Among eligible sources the lowest index wins.
- R6: A `promote_i` value of 0 to 12 names a source index. That source wins over every other maskable source whenever it is eligible. Values 13 to 15 leave the default order unchanged.
- R7: When the pin mask is 0, `xirq_i` is taken with vector 0xFFF4. It wins over every maskable source, whatever the global mask holds.
- R8: `rst_src_i` is taken with vector 0xFFFE. It wins over everything and no mask blocks it.
- R9: A request is accepted only at a clock edge where `boundary_i` is 1. `irq_o` rises in the cycle after that edge.
- R10: While `irq_o` is 1 and no acknowledge has arrived, `irq_o` and `vec_o` hold their values, and further boundary strobes are ignored.
- R11: `ack_i` while `irq_o` is 1 drops `irq_o` and sets the global mask in the next cycle. It wins over a global-mask write in the same cycle, and it also sets the pin mask when the pin or the reset-class source was taken. `ack_i` has no effect while nothing is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_req_i | input | 13 | Maskable source request levels, indexed as in R5 |
| src_en_i | input | 13 | Per-source local enables |
| promote_i | input | 4 | Promotion code selecting one source index |
| imask_we_i | input | 1 | Global mask write strobe |
| imask_d_i | input | 1 | Global mask write value |
| xmask_clr_i | input | 1 | Pin mask clear strobe |
| xirq_i | input | 1 | Separately masked external pin request |
| rst_src_i | input | 1 | Reset-class request |
| boundary_i | input | 1 | CPU instruction-boundary strobe |
| ack_i | input | 1 | CPU acknowledge (ready) |
| irq_o | output | 1 | Request to CPU (valid) |
| vec_o | output | 16 | Vector address of the held winner |
| imask_o | output | 1 | Current global mask |
| xmask_o | output | 1 | Current pin mask |

## Verification
The bench checks the promotion code in three ways: naming an eligible source, naming a source that is idle, and using an out-of-range value. A design that decoded the code wrongly would either send the idle source's vector or shuffle the default order. It also gives a second boundary strobe while a request is still held. A design without the hold would change `vec_o` under the CPU. Local enable, global mask and pin mask are each exercised with a requesting source that must stay quiet, which catches a design that drops any one of the gating terms. Acknowledge is checked both with nothing pending and against the pin mask, which exposes masks that are set at the wrong moment or never re-armed.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int unsigned N_SRC = 13;
  localparam int unsigned SEL_W = 4;
  localparam int unsigned VEC_W = 16;

  typedef logic [VEC_W-1:0] vec_t;

  typedef enum logic [1:0] {
    TAKE_NONE  = 2'd0,
    TAKE_MASK  = 2'd1,
    TAKE_XPIN  = 2'd2,
    TAKE_RESET = 2'd3
  } take_kind_e;
endpackage

// File: rtl/pic_mask_regs.sv
module pic_mask_regs (
  input  logic clk,
  input  logic rst_n,
  input  logic imask_we,
  input  logic imask_d,
  input  logic xmask_clr,
  input  logic take_ack,
  input  logic ack_sets_x,
  output logic imask,
  output logic xmask
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      imask <= 1'b1;
    end else if (take_ack) begin
      imask <= 1'b1;
    end else if (imask_we) begin
      imask <= imask_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xmask <= 1'b1;
    end else if (take_ack && ack_sets_x) begin
      xmask <= 1'b1;
    end else if (xmask_clr) begin
      xmask <= 1'b0;
    end
  end
endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter #(
  parameter int unsigned N     = 13,
  parameter int unsigned SEL_W = 4,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1,
  localparam int unsigned PAD_N = 1 << SEL_W
) (
  input  logic [N-1:0]     req,
  input  logic [N-1:0]     en,
  input  logic             gmask,
  input  logic [SEL_W-1:0] promote,
  output logic             win_valid,
  output logic [IDX_W-1:0] win_idx
);
  logic [N-1:0]     elig;
  logic [PAD_N-1:0] elig_pad;
  logic [IDX_W-1:0] dflt_idx;
  logic             promo_hit;

  for (genvar g = 0; g < N; g++) begin : g_elig
    assign elig[g] = req[g] & en[g] & ~gmask;
  end

  assign elig_pad  = PAD_N'(elig);
  assign promo_hit = (int'(promote) < int'(N)) && elig_pad[promote];

  always_comb begin
    dflt_idx = '0;
    for (int k = int'(N) - 1; k >= 0; k--) begin
      if (elig[k]) dflt_idx = IDX_W'(k);
    end
  end

  assign win_valid = |elig;
  assign win_idx   = promo_hit ? IDX_W'(promote) : dflt_idx;
endmodule

// File: rtl/pic_hold.sv
module pic_hold #(
  parameter int unsigned VEC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             boundary,
  input  logic             ack,
  input  logic             cand_valid,
  input  logic [VEC_W-1:0] cand_vec,
  input  logic             cand_sets_x,
  output logic             pend,
  output logic [VEC_W-1:0] vec,
  output logic             pend_sets_x
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend        <= 1'b0;
      vec         <= '0;
      pend_sets_x <= 1'b0;
    end else if (pend) begin
      if (ack) pend <= 1'b0;
    end else if (boundary && cand_valid) begin
      pend        <= 1'b1;
      vec         <= cand_vec;
      pend_sets_x <= cand_sets_x;
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int unsigned N       = N_SRC,
  parameter int unsigned PSEL_W  = SEL_W,
  parameter int unsigned VW      = VEC_W,
  parameter logic [VW-1:0] TOP_VEC = 16'hFFF2,
  parameter logic [VW-1:0] X_VEC   = 16'hFFF4,
  parameter logic [VW-1:0] RST_VEC = 16'hFFFE,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      src_req_i,
  input  logic [N-1:0]      src_en_i,
  input  logic [PSEL_W-1:0] promote_i,
  input  logic              imask_we_i,
  input  logic              imask_d_i,
  input  logic              xmask_clr_i,
  input  logic              xirq_i,
  input  logic              rst_src_i,
  input  logic              boundary_i,
  input  logic              ack_i,
  output logic              irq_o,
  output logic [VW-1:0]     vec_o,
  output logic              imask_o,
  output logic              xmask_o
);
  logic             win_valid;
  logic [IDX_W-1:0] win_idx;
  take_kind_e       kind;
  logic [VW-1:0]    cand_vec;
  logic             pend_sets_x;
  logic             take_ack;

  pic_arbiter #(.N(N), .SEL_W(PSEL_W)) u_arb (
    .req       (src_req_i),
    .en        (src_en_i),
    .gmask     (imask_o),
    .promote   (promote_i),
    .win_valid (win_valid),
    .win_idx   (win_idx)
  );

  always_comb begin
    if (rst_src_i) begin
      kind     = TAKE_RESET;
      cand_vec = RST_VEC;
    end else if (xirq_i && !xmask_o) begin
      kind     = TAKE_XPIN;
      cand_vec = X_VEC;
    end else if (win_valid) begin
      kind     = TAKE_MASK;
      cand_vec = TOP_VEC - VW'({win_idx, 1'b0});
    end else begin
      kind     = TAKE_NONE;
      cand_vec = '0;
    end
  end

  pic_hold #(.VEC_W(VW)) u_hold (
    .clk         (clk),
    .rst_n       (rst_n),
    .boundary    (boundary_i),
    .ack         (ack_i),
    .cand_valid  (kind != TAKE_NONE),
    .cand_vec    (cand_vec),
    .cand_sets_x (kind == TAKE_XPIN || kind == TAKE_RESET),
    .pend        (irq_o),
    .vec         (vec_o),
    .pend_sets_x (pend_sets_x)
  );

  assign take_ack = ack_i & irq_o;

  pic_mask_regs u_masks (
    .clk        (clk),
    .rst_n      (rst_n),
    .imask_we   (imask_we_i),
    .imask_d    (imask_d_i),
    .xmask_clr  (xmask_clr_i),
    .take_ack   (take_ack),
    .ack_sets_x (pend_sets_x),
    .imask      (imask_o),
    .xmask      (xmask_o)
  );
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
  parameter int unsigned VW = 16,
  parameter logic [VW-1:0] X_VEC   = 16'hFFF4,
  parameter logic [VW-1:0] RST_VEC = 16'hFFFE
) (
  input logic          clk,
  input logic          rst_n,
  input logic          boundary_i,
  input logic          ack_i,
  input logic          rst_src_i,
  input logic          irq_o,
  input logic [VW-1:0] vec_o,
  input logic          imask_o,
  input logic          xmask_o
);
  // R9: a new request only follows a boundary strobe
  a_r9_rise_needs_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(boundary_i));

  // R10: held request keeps its vector until acknowledged
  a_r10_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !ack_i) |=> (irq_o && $stable(vec_o)));

  // R11: acknowledge drops the request and sets the global mask
  a_r11_ack_masks: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && ack_i) |=> (!irq_o && imask_o));

  // R2: with the global mask set only unmaskable vectors appear
  a_r2_masked_only_nmi: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq_o) && $past(imask_o)) |-> (vec_o == X_VEC || vec_o == RST_VEC));

  // R3: pin mask is re-set only by an acknowledge
  a_r3_xmask_set_by_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xmask_o) |-> $past(ack_i && irq_o));

  // R8: reset-class request wins at its boundary
  a_r8_reset_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq_o) && $past(rst_src_i)) |-> (vec_o == RST_VEC));
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.VW(VW), .X_VEC(X_VEC), .RST_VEC(RST_VEC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .boundary_i (boundary_i),
  .ack_i      (ack_i),
  .rst_src_i  (rst_src_i),
  .irq_o      (irq_o),
  .vec_o      (vec_o),
  .imask_o    (imask_o),
  .xmask_o    (xmask_o)
);

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 13;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] src_req = '0;
  logic [NS-1:0] src_en = '0;
  logic [3:0]    promote = 4'd15;
  logic          imask_we = 1'b0, imask_d = 1'b0, xmask_clr = 1'b0;
  logic          xirq = 1'b0, rst_src = 1'b0, boundary = 1'b0, ack = 1'b0;
  logic          irq;
  logic [15:0]   vec;
  logic          imask, xmask;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  bit          seen = 1'b0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .src_req_i(src_req), .src_en_i(src_en),
    .promote_i(promote), .imask_we_i(imask_we), .imask_d_i(imask_d),
    .xmask_clr_i(xmask_clr), .xirq_i(xirq), .rst_src_i(rst_src),
    .boundary_i(boundary), .ack_i(ack), .irq_o(irq), .vec_o(vec),
    .imask_o(imask), .xmask_o(xmask)
  );

  function automatic logic [15:0] src_vec(int k);
    return 16'hFFF2 - 16'(2 * k);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard when a new request appears
  always @(negedge clk) begin
    if (rst_n && irq && !seen) begin
      seen = 1'b1;
      n_chk++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL unexpected request: actual 0x%0h expected none", vec);
      end else begin
        automatic logic [15:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (vec !== e) begin
          n_bad++;
          $display("FAIL %s: actual 0x%0h expected 0x%0h", t, vec, e);
        end
      end
    end else if (!irq) begin
      seen = 1'b0;
    end
  end

  task automatic set_i(logic v);
    @(negedge clk); imask_we = 1'b1; imask_d = v;
    @(negedge clk); imask_we = 1'b0;
  endtask

  task automatic strobe();
    @(negedge clk); boundary = 1'b1;
    @(negedge clk); boundary = 1'b0;
  endtask

  task automatic do_ack();
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
  endtask

  task automatic expect_take(logic [15:0] e, string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    strobe();
    @(negedge clk);
    if (exp_q.size() != 0) begin
      n_chk++;
      n_bad++;
      $display("FAIL %s: actual no request expected 0x%0h", tag, e);
      void'(exp_q.pop_front());
      void'(tag_q.pop_front());
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 imask", imask, 1);
    chk("R1 xmask", xmask, 1);
    chk("R1 irq", irq, 0);

    // R2: masked maskable source is not taken
    src_en = '1;
    src_req = 13'b1;
    strobe(); @(negedge clk);
    chk("R2 masked no irq", irq, 0);

    // R5: default winner vectors
    set_i(1'b0);
    chk("R2 write clears imask", imask, 0);
    expect_take(src_vec(0), "R5 external request");
    do_ack();
    chk("R11 ack drops irq", irq, 0);
    chk("R11 ack sets imask", imask, 1);

    src_req = '0; src_req[5] = 1'b1; src_req[10] = 1'b1;
    set_i(1'b0);
    expect_take(src_vec(5), "R5 compare1 over overflow");
    do_ack();

    // R4: local enable
    src_req = '0; src_req[3] = 1'b1; src_req[12] = 1'b1;
    src_en = '1; src_en[3] = 1'b0;
    set_i(1'b0);
    expect_take(src_vec(12), "R4 disabled capture skipped");
    do_ack();
    src_en = '1;

    // R6: promotion
    src_req = '0; src_req[1] = 1'b1; src_req[12] = 1'b1;
    promote = 4'd12;
    set_i(1'b0);
    expect_take(src_vec(12), "R6 promoted serial");
    do_ack();
    promote = 4'd15;
    set_i(1'b0);
    expect_take(src_vec(1), "R6 unused code default");
    do_ack();
    src_req = '0; src_req[4] = 1'b1; src_req[7] = 1'b1;
    promote = 4'd12;
    set_i(1'b0);
    expect_take(src_vec(4), "R6 promoted source idle");
    do_ack();
    promote = 4'd15;

    // R9: no boundary, no request
    src_req = 13'b1;
    set_i(1'b0);
    repeat (4) @(negedge clk);
    chk("R9 no strobe no irq", irq, 0);

    // R10: hold while pending
    expect_take(src_vec(0), "R10 first take");
    src_req = '0; src_req[1] = 1'b1;
    rst_src = 1'b1;
    strobe();
    rst_src = 1'b0;
    chk("R10 irq held", irq, 1);
    chk("R10 vec held", vec, src_vec(0));
    do_ack();
    src_req = '0;

    // R3 / R7: separately masked pin
    set_i(1'b0);
    xirq = 1'b1;
    strobe(); @(negedge clk);
    chk("R3 pin ignored while masked", irq, 0);
    @(negedge clk); xmask_clr = 1'b1;
    @(negedge clk); xmask_clr = 1'b0;
    chk("R3 clear pin mask", xmask, 0);
    set_i(1'b1);
    src_req = 13'b1;
    expect_take(16'hFFF4, "R7 pin wins under global mask");
    do_ack();
    chk("R11 pin ack sets xmask", xmask, 1);
    chk("R11 pin ack sets imask", imask, 1);
    xirq = 1'b0;

    // R8: reset-class source
    rst_src = 1'b1; xirq = 1'b1;
    expect_take(16'hFFFE, "R8 reset-class wins");
    rst_src = 1'b0; xirq = 1'b0;
    do_ack();
    src_req = '0;

    // R11: ack with nothing pending is ignored
    set_i(1'b0);
    do_ack();
    chk("R11 idle ack keeps imask", imask, 0);
    chk("R11 idle ack no irq", irq, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule